// File: doc/BRIEF.md
# FMA special-case result selector

This unit sits directly behind a single-precision fused multiply-add datapath and decides which word leaves the pipe. The datapath delivers its raw 32-bit result together with its exception flags. The unit also sees the three original operands (multiplicand `a`, multiplier `b`, addend `c`) and a subtract select, which means the product is negated relative to the addend. When the datapath flags an invalid operation, the unit classifies the operands and substitutes a quiet NaN. The low fraction bits of that NaN carry a code that names the cause, so later software can tell why the result is invalid.

Each operand is classified after any subnormal value has been flushed to a zero of the same sign. The causes are tested in a fixed order:
1. a NaN operand of either kind (quiet or signalling);
2. an infinite factor multiplied by a zero factor;
3. infinities that meet with opposite effective signs.

If none of these matches, the raw word passes through unchanged. The exception flags are forwarded to the output, along with a summary bit that is high only when at least one flag is set. The output stage is registered, so each accepted input appears one cycle later.

Top module: `fma_nan_fixup`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `out_valid`, `out_res`, `out_exc` and `out_any` become zero.
- R2: `out_valid` is `in_valid` delayed by one cycle. The output registers load only when `in_valid` is high and otherwise keep their value.
- R3: When the invalid bit (bit 0 of `raw_exc`) is clear, `out_res` equals `raw_res`.
- R4: With the invalid bit set, if any operand has an all-ones exponent and a non-zero fraction, `out_res` is 0x7FC00000.
- R5: With the invalid bit set and no NaN operand, if one of `a` and `b` is infinite and the other is zero, `out_res` is 0x7FC00002.
- R6: With the invalid bit set and neither rule above matching, if `a` or `b` has an all-ones exponent, `c` has an all-ones exponent, and sign(a)^sign(b)^sign(c) is 1, then `out_res` is 0x7FC00001.
- R7: When `sub_mode` is 1, the sign of `c` is inverted before the sign test of R6.
- R8: The rules apply in strict priority: R4 first, then R5, then R6.
- R9: An operand with a zero exponent and a non-zero fraction counts as zero in every classification.
- R10: With the invalid bit set and no rule matching, `out_res` equals `raw_res`.
- R11: `out_exc` is a copy of `raw_exc`. `out_any` is 1 exactly when `raw_exc` is non-zero, and is cleared when the datapath reports no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands, raw result and flags are valid this cycle |
| sub_mode | input | 1 | 1 = product negated relative to the addend |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| raw_res | input | 32 | Result word from the datapath |
| raw_exc | input | 4 | Datapath flags; bit 0 = invalid operation |
| out_valid | output | 1 | Registered result valid |
| out_res | output | 32 | Final result |
| out_exc | output | 4 | Registered copy of the flags |
| out_any | output | 1 | Summary: any flag set |

## Verification
The assertions assume that `in_valid`, `raw_exc` and the operands are settled during the cycle in which they are sampled. They also assume that invalid and non-invalid vectors can arrive back to back with no idle cycle between them. The bench drives every input on the falling edge and holds it for one full cycle. Its directed vectors deliberately raise the invalid flag on operands where no rule applies, and clear it on operands where a rule would apply. This shows that the datapath's flag, not the operand class, gates the override. Randomised vectors mix infinities, signed zeros, subnormals and both NaN kinds, so the priority order gets exercised on overlapping cases.

// File: rtl/fnf_pkg.sv
// Shared types for the FMA special-case result selector.
// Assumes single precision by default; widths are parameters of the modules.
package fnf_pkg;

    // Per-operand classification after subnormal flushing.
    typedef struct packed {
        logic sign;
        logic exp_max;
        logic is_nan;
        logic is_inf;
        logic is_zero;
    } fnf_cls_t;

    // Which word the selector forwards.
    typedef enum logic [1:0] {
        SEL_RAW  = 2'd0,
        SEL_NAN  = 2'd1,
        SEL_MULZ = 2'd2,
        SEL_INFS = 2'd3
    } fnf_sel_e;

    // Cause codes placed in the low fraction bits of the quiet NaN.
    localparam int CAUSE_NAN_IN  = 0;
    localparam int CAUSE_INF_SUB = 1;
    localparam int CAUSE_INF_MUL = 2;

endpackage

// File: rtl/fnf_classify.sv
// Classifies one floating-point operand.
// Subnormal inputs (zero exponent, non-zero fraction) count as zero of the
// same sign. Assumes IEEE-754 layout: sign MSB, then exponent, then fraction.
module fnf_classify
    import fnf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output fnf_cls_t              cls
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = op[WORD_W-2 -: EXP_W];
    assign frac = op[FRAC_W-1:0];

    // Derive class bits; a zero exponent means zero whatever the fraction.
    always_comb begin
        cls.sign    = op[WORD_W-1];
        cls.exp_max = &expo;
        cls.is_nan  = (&expo) && (|frac);
        cls.is_inf  = (&expo) && !(|frac);
        cls.is_zero = !(|expo);
    end
endmodule

// File: rtl/fnf_select.sv
// Priority selector: picks the raw word or a cause-coded quiet NaN.
// Overrides are considered only while the datapath reports invalid.
module fnf_select
    import fnf_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fnf_cls_t              cls_a,
    input  fnf_cls_t              cls_b,
    input  fnf_cls_t              cls_c,
    input  logic                  sub_mode,
    input  logic                  invalid,
    input  logic [EXP_W+FRAC_W:0] raw_res,
    output fnf_sel_e              sel,
    output logic [EXP_W+FRAC_W:0] fixed_res
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] QNAN_BASE =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic any_nan;
    logic mul_inf_zero;
    logic opp_inf;

    // Evaluate each cause independently of priority.
    always_comb begin
        any_nan      = cls_a.is_nan | cls_b.is_nan | cls_c.is_nan;
        mul_inf_zero = (cls_a.is_inf & cls_b.is_zero) |
                       (cls_a.is_zero & cls_b.is_inf);
        opp_inf      = (cls_a.exp_max | cls_b.exp_max) & cls_c.exp_max &
                       (cls_a.sign ^ cls_b.sign ^ cls_c.sign ^ sub_mode);
    end

    // Apply the fixed priority: NaN input, then inf*0, then opposing infinities.
    always_comb begin
        sel = SEL_RAW;
        if (invalid) begin
            if (any_nan)           sel = SEL_NAN;
            else if (mul_inf_zero) sel = SEL_MULZ;
            else if (opp_inf)      sel = SEL_INFS;
        end
    end

    // Map the selection onto the output word.
    always_comb begin
        unique case (sel)
            SEL_NAN:  fixed_res = QNAN_BASE | WORD_W'(CAUSE_NAN_IN);
            SEL_MULZ: fixed_res = QNAN_BASE | WORD_W'(CAUSE_INF_MUL);
            SEL_INFS: fixed_res = QNAN_BASE | WORD_W'(CAUSE_INF_SUB);
            default:  fixed_res = raw_res;
        endcase
    end
endmodule

// File: rtl/fma_nan_fixup.sv
// FMA special-case result selector (top).
// Classifies the three operands, chooses the final word and registers it
// with its flags; one cycle from in_valid to out_valid.
// Assumes all inputs are stable around the sampling clock edge.
module fma_nan_fixup
    import fnf_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int EXC_W   = 4,
    parameter int INV_IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  sub_mode,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  logic [EXP_W+FRAC_W:0] raw_res,
    input  logic [EXC_W-1:0]      raw_exc,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_res,
    output logic [EXC_W-1:0]      out_exc,
    output logic                  out_any
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 3;
    localparam logic [WORD_W-1:0] QNAN_BASE =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] ops [N_OPS];
    fnf_cls_t          cls [N_OPS];
    fnf_sel_e          sel;
    logic [WORD_W-1:0] fixed_res;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fnf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op  (ops[gi]),
            .cls (cls[gi])
        );
    end

    fnf_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .cls_c     (cls[2]),
        .sub_mode  (sub_mode),
        .invalid   (raw_exc[INV_IDX]),
        .raw_res   (raw_res),
        .sel       (sel),
        .fixed_res (fixed_res)
    );

    // Output stage: load on in_valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_exc   <= '0;
            out_any   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= fixed_res;
                out_exc <= raw_exc;
                out_any <= |raw_exc;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_exc)));

    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !raw_exc[INV_IDX]) |=> (out_res == $past(raw_res)));

    // R4
    nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && raw_exc[INV_IDX] &&
         (cls[0].is_nan || cls[1].is_nan || cls[2].is_nan))
        |=> (out_res == QNAN_BASE));

    // R11
    summary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (raw_exc == '0)) |=> !out_any);

    // R11
    summary_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (raw_exc != '0)) |=> out_any);
endmodule

// File: tb/fma_nan_fixup_tb.sv
`timescale 1ns/1ps
module fma_nan_fixup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sub_mode = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, raw_res = '0;
    logic [3:0]  raw_exc = '0;
    logic        out_valid, out_any;
    logic [31:0] out_res;
    logic [3:0]  out_exc;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    fma_nan_fixup u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_mode(sub_mode),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .raw_res(raw_res),
        .raw_exc(raw_exc), .out_valid(out_valid), .out_res(out_res),
        .out_exc(out_exc), .out_any(out_any)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] flush(input logic [31:0] x);
        if (x[30:23] == 8'd0) return {x[31], 31'd0};
        return x;
    endfunction

    function automatic bit f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit f_inf(input logic [31:0] x);
        return x[30:0] == 31'h7F800000;
    endfunction

    function automatic bit f_zero(input logic [31:0] x);
        return x[30:0] == 31'd0;
    endfunction

    function automatic logic [31:0] ref_fix(input logic [31:0] a0, b0, c0, raw,
                                            input logic inv, input logic sub);
        logic [31:0] a, b, c;
        a = flush(a0); b = flush(b0); c = flush(c0);
        if (!inv) return raw;
        if (f_nan(a) || f_nan(b) || f_nan(c)) return 32'h7FC00000;
        if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) return 32'h7FC00002;
        if ((a[30:23] == 8'hFF || b[30:23] == 8'hFF) && c[30:23] == 8'hFF &&
            ((a[31] ^ b[31] ^ c[31] ^ sub) == 1'b1)) return 32'h7FC00001;
        return raw;
    endfunction

    logic        m_valid = 0, m_any = 0;
    logic [31:0] m_res = '0;
    logic [3:0]  m_exc = '0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_res <= '0; m_exc <= '0; m_any <= 0; m_tag <= "R1";
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                m_res <= ref_fix(op_a, op_b, op_c, raw_res, raw_exc[0], sub_mode);
                m_exc <= raw_exc;
                m_any <= (raw_exc != 4'd0);
                m_tag <= cur_tag;
            end else begin
                m_tag <= "R2";
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check(rst_n ? "R2 valid" : "R1 valid", {31'd0, out_valid}, {31'd0, m_valid});
            check({m_tag, " result"}, out_res, m_res);
            check("R11 flags", {28'd0, out_exc}, {28'd0, m_exc});
            check("R11 summary", {31'd0, out_any}, {31'd0, m_any});
        end
    end

    task automatic apply(input string tag, input logic [31:0] a, b, c, raw,
                         input logic [3:0] exc, input logic sub);
        @(negedge clk);
        cur_tag = tag; op_a = a; op_b = b; op_c = c; raw_res = raw;
        raw_exc = exc; sub_mode = sub; in_valid = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        op_a = 32'hDEADBEEF; raw_res = 32'h0BADF00D; raw_exc = 4'hF;
    endtask

    function automatic logic [31:0] pick(input int unsigned r, input int unsigned s);
        logic sg;
        sg = s[0];
        case (r % 8)
            0: return {sg, 31'h7F800000};
            1: return {sg, 31'h00000000};
            2: return {sg, 8'd0, 23'(s >> 1) | 23'd1};
            3: return {sg, 31'h7FC00000};
            4: return {sg, 31'h7F800010};
            5: return {sg, 31'h3F800000};
            default: return {sg, 8'd1 + 8'(s % 200), 23'(s >> 3)};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: clean operations pass through
        apply("R3", 32'h3F800000, 32'h40000000, 32'h40400000, 32'h40A00000, 4'h0, 0);
        apply("R3", 32'h7FC00000, 32'h3F800000, 32'h0, 32'h12345678, 4'h0, 0);
        apply("R11", 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h40000000, 4'h8, 0);
        // R4: NaN operands, quiet and signalling
        apply("R4", 32'h7FC00000, 32'h3F800000, 32'h0, 32'h1, 4'h1, 0);
        apply("R4", 32'h3F800000, 32'hFF800001, 32'h0, 32'h1, 4'h1, 0);
        apply("R4", 32'h3F800000, 32'h3F800000, 32'h7F800010, 32'h1, 4'h1, 1);
        // R5: infinity times zero
        apply("R5", 32'h7F800000, 32'h00000000, 32'h3F800000, 32'h2, 4'h1, 0);
        apply("R5", 32'h80000000, 32'hFF800000, 32'h3F800000, 32'h2, 4'h1, 1);
        // R9: subnormal counts as zero
        apply("R9", 32'h7F800000, 32'h00000001, 32'h3F800000, 32'h3, 4'h1, 0);
        apply("R9", 32'h807FFFFF, 32'h7F800000, 32'h0, 32'h3, 4'h1, 0);
        // R6 / R7: opposing infinities
        apply("R6", 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h4, 4'h1, 0);
        apply("R7", 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7F800000, 4'h1, 1);
        apply("R7", 32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h5, 4'h1, 1);
        // R8: priority
        apply("R8", 32'h7F800000, 32'h00000000, 32'h7FC00000, 32'h6, 4'h1, 0);
        apply("R8", 32'h7F800000, 32'h00000000, 32'hFF800000, 32'h6, 4'h1, 0);
        // R10: invalid but no rule applies
        apply("R10", 32'h3F800000, 32'h40000000, 32'h40400000, 32'h12345678, 4'h1, 0);
        idle(); idle(); idle();
        apply("R2", 32'h3F800000, 32'h3F800000, 32'h0, 32'hCAFEF00D, 4'h0, 0);
        idle(); idle();
        // Randomised mix of special values
        for (int i = 0; i < 400; i++) begin
            apply("R8", pick($urandom, $urandom), pick($urandom, $urandom),
                  pick($urandom, $urandom), $urandom, 4'($urandom), 1'($urandom));
            if (i % 7 == 0) idle();
        end
        idle(); idle();
        // R1: reset clears outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule